// File: doc/BRIEF.md
# Standby-Aware GPIO Port Controller

This block controls an eight-pin general-purpose I/O port. Software-side registers hold, for each pin, an output latch value, a drive direction, a pull-up request and (on the low four pins) an analog-select flag. From these and from the power manager's stop, sleep and standby-hold inputs, the block drives per-pin output-enable, output-value and pull-up-enable signals to the pad ring. Raw pad levels return through a two-flop synchroniser to the core, and unsynchronised to the interrupt path.

When the port is stopped with the standby-hold input high, the block enters a frozen state. Every driver is released whatever the direction register holds. A pin whose pull-up is requested rests high; any other pin floats. The core-visible inputs are clamped to zero so that a floating pad cannot leak, while the interrupt path keeps carrying live pad levels for wake-up. During reset every driver and every pull-up is off.

Top module: `gpio_standby_port`

## Requirements
- R1: While rst_n is low, pad_oe and pad_pu are all zero and every register reads zero. Reset is asynchronous, and after release all pins are inputs with pull-ups and analog select off.
- R2: A write with wr_en high stores wr_data into the register chosen by wr_sel, visible from the next clock edge. The codes are 0 output latch, 1 direction, 2 pull-up and 3 analog select. rd_sel uses the same codes, and the direction, pull-up and analog codes read back the stored value.
- R3: Outside the frozen state, pad_oe[i] equals direction bit i (unless analog select is on for pin i), and pad_out[i] equals latch bit i.
- R4: pad_pu[i] is high exactly when pull-up bit i is set, reset is released and pad_oe[i] is low.
- R5: With stop and stby_hold both high (the frozen state), every pad_oe bit is 0 whatever the direction register holds. Pins with their pull-up bit set still get pad_pu high.
- R6: In the frozen state core_in reads all zero. A read with code 0 then returns the latch for output pins and 0 for input pins.
- R7: irq_in equals pad_in combinationally in every mode, including the frozen state.
- R8: Sleep alone, or stop with stby_hold low, leaves pin behaviour identical to normal run.
- R9: Analog select exists only on pins 0 to 3. A set bit forces that pin's pad_oe and core_in to 0, and ana_sel carries the four bits. Written bits 4 to 7 are discarded and read as 0.
- R10: core_in[i] follows pad_in[i] after two rising clock edges. A read with code 0 returns the latch bit for pins whose direction bit is 1 and core_in for pins whose direction bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop | input | 1 | Stop mode from the power manager |
| sleep | input | 1 | Sleep mode from the power manager (no pin effect) |
| stby_hold | input | 1 | Standby pin-state control: 1 releases pins in stop |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 8 | Read data |
| pad_in | input | 8 | Raw pad input levels |
| pad_oe | output | 8 | Pad output-driver enable |
| pad_out | output | 8 | Pad output value |
| pad_pu | output | 8 | Pad pull-up enable |
| core_in | output | 8 | Synchronised, gated pin inputs to the core |
| irq_in | output | 8 | Live pad levels for the interrupt path |
| ana_sel | output | 4 | Analog-select flags for pins 0 to 3 |

## Verification
On every cycle, the assertions check the following:
- the drivers are released and the core inputs clamped while frozen;
- analog-selected pins stay undriven;
- reset silences drivers and pull-ups;
- direction writes land on the following edge;
- sleep leaves pin behaviour unchanged;
- the synchroniser output lags the pad by exactly two edges.

Only the bench scenarios can show the following:
- pull-ups lifting a frozen pin;
- the mixed read value, which merges latch and pad across directions;
- the interrupt path staying live while the core input is frozen;
- the upper analog bits being discarded.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   typedef enum logic [1:0] {
      SEL_LATCH = 2'd0,
      SEL_DIR   = 2'd1,
      SEL_PULL  = 2'd2,
      SEL_ANA   = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage_q [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("gpio_sync needs at least two stages");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[0] <= '0;
               else        stage_q[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_port_pkg::*;
#(
   parameter int NPINS   = 8,
   parameter int NANALOG = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [NPINS-1:0] wr_data,
   output logic [NPINS-1:0] latch_q,
   output logic [NPINS-1:0] dir_q,
   output logic [NPINS-1:0] pull_q,
   output logic [NPINS-1:0] ana_q
);
   reg_sel_e wsel;
   assign wsel = reg_sel_e'(wr_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         dir_q   <= '0;
         pull_q  <= '0;
      end else if (wr_en) begin
         if (wsel == SEL_LATCH) latch_q <= wr_data;
         if (wsel == SEL_DIR)   dir_q   <= wr_data;
         if (wsel == SEL_PULL)  pull_q  <= wr_data;
      end
   end

   generate
      for (genvar i = 0; i < NPINS; i++) begin : g_ana
         if (i < NANALOG) begin : g_store
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                       ana_q[i] <= 1'b0;
               else if (wr_en && wsel == SEL_ANA) ana_q[i] <= wr_data[i];
            end
         end else begin : g_none
            assign ana_q[i] = 1'b0;
         end
      end
   endgenerate

   // R2
   dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wsel == SEL_DIR) |=> (dir_q == $past(wr_data)));
   // R2
   pull_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wsel == SEL_PULL) |=> (pull_q == $past(wr_data)));
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic freeze,
   input  logic dir,
   input  logic latch,
   input  logic pull,
   input  logic ana,
   input  logic sync_in,
   output logic oe,
   output logic out,
   output logic pu,
   output logic core_in
);
   logic drive_ok;
   assign drive_ok = rst_n && !freeze && !ana;

   assign oe      = dir && drive_ok;
   assign out     = latch;
   assign pu      = pull && rst_n && !oe;
   assign core_in = sync_in && !freeze && !ana;

   // R5
   hold_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |-> !oe);
   // R6
   hold_in_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |-> !core_in);
   // R9
   ana_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ana |-> (!oe && !core_in));
   // R1
   always_comb begin
      if (!rst_n) begin
         rst_quiet_chk: assert (!oe && !pu);
      end
   end
endmodule

// File: rtl/gpio_standby_port.sv
module gpio_standby_port
   import gpio_port_pkg::*;
#(
   parameter int NPINS       = 8,
   parameter int NANALOG     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               stop,
   input  logic               sleep,
   input  logic               stby_hold,
   input  logic               wr_en,
   input  logic [1:0]         wr_sel,
   input  logic [NPINS-1:0]   wr_data,
   input  logic [1:0]         rd_sel,
   output logic [NPINS-1:0]   rd_data,
   input  logic [NPINS-1:0]   pad_in,
   output logic [NPINS-1:0]   pad_oe,
   output logic [NPINS-1:0]   pad_out,
   output logic [NPINS-1:0]   pad_pu,
   output logic [NPINS-1:0]   core_in,
   output logic [NPINS-1:0]   irq_in,
   output logic [NANALOG-1:0] ana_sel
);
   generate
      if (NANALOG < 1 || NANALOG > NPINS) begin : g_bad_ana
         $error("NANALOG must lie between 1 and NPINS");
      end
      if (NPINS < 1) begin : g_bad_pins
         $error("NPINS must be positive");
      end
   endgenerate

   logic [NPINS-1:0] latch_q, dir_q, pull_q, ana_q, sync_q;
   logic             freeze;

   assign freeze = stop && stby_hold;

   gpio_regs #(.NPINS(NPINS), .NANALOG(NANALOG)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .latch_q(latch_q), .dir_q(dir_q),
      .pull_q(pull_q), .ana_q(ana_q)
   );

   gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(sync_q)
   );

   generate
      for (genvar i = 0; i < NPINS; i++) begin : g_pin
         gpio_pin_cell u_cell (
            .clk(clk), .rst_n(rst_n), .freeze(freeze),
            .dir(dir_q[i]), .latch(latch_q[i]), .pull(pull_q[i]),
            .ana(ana_q[i]), .sync_in(sync_q[i]),
            .oe(pad_oe[i]), .out(pad_out[i]), .pu(pad_pu[i]),
            .core_in(core_in[i])
         );
      end
   endgenerate

   assign irq_in  = pad_in;
   assign ana_sel = ana_q[NANALOG-1:0];

   reg_sel_e rsel;
   assign rsel = reg_sel_e'(rd_sel);

   always_comb begin
      case (rsel)
         SEL_LATCH: rd_data = (dir_q & latch_q) | (~dir_q & core_in);
         SEL_DIR:   rd_data = dir_q;
         SEL_PULL:  rd_data = pull_q;
         default:   rd_data = ana_q;
      endcase
   end

   // R8
   sleep_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep && !freeze) |-> (pad_oe == (dir_q & ~ana_q)));

   generate
      if (SYNC_STAGES == 2) begin : g_sync_chk
         logic [1:0] up_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             up_cnt <= '0;
            else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
         end
         // R10
         sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (up_cnt == 2'd3) |-> (sync_q == $past(pad_in, 2)));
      end
   endgenerate
endmodule

// File: tb/sim_gpio_standby_port.sv
module sim_gpio_standby_port;
   logic       clk = 1'b0;
   logic       rst_n, stop, sleep, stby_hold, wr_en;
   logic [1:0] wr_sel, rd_sel;
   logic [7:0] wr_data, rd_data, pad_in, pad_oe, pad_out, pad_pu, core_in, irq_in;
   logic [3:0] ana_sel;
   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   gpio_standby_port u0 (
      .clk(clk), .rst_n(rst_n), .stop(stop), .sleep(sleep),
      .stby_hold(stby_hold), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
      .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
      .pad_pu(pad_pu), .core_in(core_in), .irq_in(irq_in),
      .ana_sel(ana_sel)
   );

   task automatic check(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic write_reg(input logic [1:0] sel, input logic [7:0] val);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = val;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic read_reg(input logic [1:0] sel, output logic [7:0] val);
      rd_sel = sel;
      #0.5;
      val = rd_data;
   endtask

   task automatic settle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [7:0] v;
      pad_in = 8'hFF;
      settle(2);
      check("R1", "oe in reset", pad_oe, 8'h00);
      check("R1", "pu in reset", pad_pu, 8'h00);
      check("R1", "core_in in reset", core_in, 8'h00);
      read_reg(2'd1, v); check("R1", "dir in reset", v, 8'h00);
      @(negedge clk); rst_n = 1'b1;
      settle(1);
      check("R1", "oe after release", pad_oe, 8'h00);
   endtask

   task automatic t_regs;
      logic [7:0] v;
      write_reg(2'd0, 8'hA5);
      write_reg(2'd1, 8'h0F);
      write_reg(2'd2, 8'hF0);
      write_reg(2'd3, 8'hFF);
      read_reg(2'd1, v); check("R2", "dir readback", v, 8'h0F);
      read_reg(2'd2, v); check("R2", "pull readback", v, 8'hF0);
      read_reg(2'd3, v); check("R9", "analog upper bits dropped", v, 8'h0F);
      check("R9", "ana_sel", {4'h0, ana_sel}, 8'h0F);
      check("R9", "oe with analog", pad_oe, 8'h00);
      write_reg(2'd3, 8'h00);
   endtask

   task automatic t_normal;
      logic [7:0] v;
      pad_in = 8'h3C;
      settle(3);
      check("R3", "oe follows dir", pad_oe, 8'h0F);
      check("R3", "out follows latch", pad_out, 8'hA5);
      read_reg(2'd0, v); check("R10", "mixed read", v, 8'h35);
   endtask

   task automatic t_pullup;
      write_reg(2'd2, 8'hFF);
      check("R4", "pu on input pins only", pad_pu, 8'hF0);
   endtask

   task automatic t_frozen;
      logic [7:0] v;
      @(negedge clk); stop = 1'b1; stby_hold = 1'b1;
      settle(1);
      check("R5", "oe released", pad_oe, 8'h00);
      check("R5", "pu holds pins high", pad_pu, 8'hFF);
      check("R6", "core_in clamped", core_in, 8'h00);
      read_reg(2'd0, v); check("R6", "frozen read", v, 8'h05);
      pad_in = 8'hC3; #0.5;
      check("R7", "irq_in live", irq_in, 8'hC3);
      settle(3);
      check("R6", "core_in still clamped", core_in, 8'h00);
   endtask

   task automatic t_unfrozen_modes;
      @(negedge clk); stby_hold = 1'b0;
      settle(1);
      check("R8", "stop hold0 oe", pad_oe, 8'h0F);
      check("R8", "stop hold0 core_in", core_in, 8'hC3);
      @(negedge clk); stop = 1'b0; sleep = 1'b1; stby_hold = 1'b1;
      settle(1);
      check("R8", "sleep oe", pad_oe, 8'h0F);
      check("R8", "sleep pu", pad_pu, 8'hF0);
      check("R8", "sleep core_in", core_in, 8'hC3);
      @(negedge clk); sleep = 1'b0; stby_hold = 1'b0;
   endtask

   task automatic t_analog;
      write_reg(2'd3, 8'h0C);
      check("R9", "analog oe", pad_oe, 8'h03);
      check("R9", "analog core_in", core_in, 8'hC3 & 8'hF3);
      write_reg(2'd3, 8'h00);
   endtask

   task automatic t_sync;
      @(negedge clk); pad_in = 8'h5A;
      check("R7", "irq immediate", irq_in, 8'h5A);
      @(negedge clk);
      check("R10", "one edge old", core_in, 8'hC3);
      @(negedge clk);
      check("R10", "two edges new", core_in, 8'h5A);
   endtask

   task automatic t_reset_pull;
      @(negedge clk); rst_n = 1'b0;
      #0.5;
      check("R1", "pu off in reset", pad_pu, 8'h00);
      check("R1", "oe off in reset", pad_oe, 8'h00);
      @(negedge clk); rst_n = 1'b1;
      settle(1);
      check("R1", "pull cleared", pad_pu, 8'h00);
   endtask

   initial begin
      rst_n = 1'b0; stop = 1'b0; sleep = 1'b0; stby_hold = 1'b0;
      wr_en = 1'b0; wr_sel = '0; wr_data = '0; rd_sel = '0; pad_in = '0;
      t_reset;
      t_regs;
      t_normal;
      t_pullup;
      t_frozen;
      t_unfrozen_modes;
      t_analog;
      t_sync;
      t_reset_pull;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule